// File: doc/BRIEF.md
# Receive and Transmit Interrupt Delay Timers

This block moderates completion interrupts for a network controller. Each direction (receive and transmit) owns a pair of timers. The first is a packet timer, which starts again on every qualifying completion. The second is an absolute timer, which starts at the first qualifying completion and is never extended, so the total wait has an upper bound. When either timer runs out, the block posts a completion cause for that direction. Delay values count in ticks of 1024 ns. Each timer divides the core clock down to that tick itself, so its expiry lands on an exact cycle.

Causes are merged in one place. When anything is posted in a cycle, every timer still running is cancelled and its cause is folded into that posting. The trigger can be a timer expiry, an immediate receive cause, a small-packet cause, a flush, or an interrupt raised elsewhere in the controller (`int_post_i`). An interrupt therefore always carries every completion that is still waiting. A read of the receive delay register while its flush bit is set forces an immediate receive cause and asks for the flush bit to be cleared.

Top module: `int_delay_timers`

## Requirements
- R1: After reset, all four timers are idle, and every cause output and `flush_clr_o` is low.
- R2: A receive completion with a nonzero packet delay D arms the receive packet timer, restarting it if it is already running. Unless a posting intervenes, `rx_cause_o` rises D×PRESC cycles after the last arming edge, where PRESC = TICK_NS/CLK_NS (128 by default).
- R3: A receive completion with a zero packet delay raises `rx_cause_o` in the next cycle and arms no receive timer.
- R4: The receive absolute timer starts only when both its delay A and the packet delay are nonzero and it is idle. Later completions do not extend it, so the receive cause comes at most A×PRESC cycles after the first arming.
- R5: A receive completion whose length is less than or equal to `small_thr_i` raises `small_cause_o` in the next cycle.
- R6: Transmit timers arm only on completions with `tx_dly_en_i` high, following the same restart and start-once rules as R2 and R4. A transmit expiry raises `tx_cause_o`.
- R7: Any posting cancels all running timers. The same cycle sets `rx_cause_o` if a receive timer was running or was being armed, and sets `tx_cause_o` if a transmit timer was running or was being armed.
- R8: A cycle with `dly_rd_i` and `flush_bit_i` both high raises `rx_cause_o` and `flush_clr_o` in the next cycle. With `flush_bit_i` low, a read has no effect.
- R9: A timer never goes idle, whether by expiry or by cancellation, without its direction's cause output being raised in the same cycle.
- R10: `int_post_i` with no timer running and no arming in that cycle raises no cause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_done_i | input | 1 | One-cycle pulse for a receive completion |
| rx_len_i | input | LEN_W | Length of the completed receive packet |
| tx_done_i | input | 1 | One-cycle pulse for a transmit completion |
| tx_dly_en_i | input | 1 | The completion's descriptor requests delayed interrupt |
| rx_pkt_dly_i | input | DLY_W | Receive packet delay in ticks |
| rx_abs_dly_i | input | DLY_W | Receive absolute delay in ticks |
| tx_pkt_dly_i | input | DLY_W | Transmit packet delay in ticks |
| tx_abs_dly_i | input | DLY_W | Transmit absolute delay in ticks |
| small_thr_i | input | LEN_W | Small-packet length threshold |
| dly_rd_i | input | 1 | Read strobe for the receive delay register |
| flush_bit_i | input | 1 | Current value of the flush bit |
| int_post_i | input | 1 | Interrupt posted elsewhere in the controller |
| rx_cause_o | output | 1 | Receive completion cause pulse |
| tx_cause_o | output | 1 | Transmit completion cause pulse |
| small_cause_o | output | 1 | Small-packet cause pulse |
| flush_clr_o | output | 1 | Request to clear the flush bit |
| rx_pkt_busy_o | output | 1 | Receive packet timer running |
| rx_abs_busy_o | output | 1 | Receive absolute timer running |
| tx_pkt_busy_o | output | 1 | Transmit packet timer running |
| tx_abs_busy_o | output | 1 | Transmit absolute timer running |

## Verification
The assertions check, on every cycle, the one-cycle responses and the cause invariants. These are the immediate receive cause, the small-packet cause, the flush, cancellation on an external posting, that no timer goes idle without its cause, and that a transmit cause always has a running or arming transmit timer behind it. Only the bench scenarios can show the exact expiry cycle of each timer. They also show that a second completion restarts the packet timer while leaving the absolute timer alone, and that the absolute timer caps a stream of closely spaced completions. Those properties depend on windows hundreds of cycles long.

// File: rtl/idt_pkg.sv
package idt_pkg;
  localparam int DIR_RX  = 0;
  localparam int DIR_TX  = 1;
  localparam int NUM_DIR = 2;

  typedef struct packed {
    logic pkt_busy;
    logic abs_busy;
    logic expire;
    logic arm;
  } dir_stat_t;
endpackage

// File: rtl/idt_timer.sv
module idt_timer #(
  parameter int DLY_W = 16,
  parameter int PRESC = 128,
  localparam int CW = DLY_W + $clog2(PRESC) + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic             start_i,
  input  logic             cancel_i,
  input  logic [DLY_W-1:0] delay_i,
  output logic             busy_o,
  output logic             expire_o
);
  logic [CW-1:0] cnt_q;
  logic          busy_q;
  logic [CW-1:0] load_val;
  logic          arm;

  // delay in ticks scaled to core cycles, minus one for the arming edge
  assign load_val = CW'(delay_i) * CW'(PRESC) - CW'(1);
  assign arm      = restart_i | (start_i & ~busy_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (cancel_i) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (arm) begin
      busy_q <= 1'b1;
      cnt_q  <= load_val;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - CW'(1);
    end
  end

  assign busy_o   = busy_q;
  assign expire_o = busy_q & (cnt_q == '0);
endmodule

// File: rtl/idt_dir_pair.sv
module idt_dir_pair
  import idt_pkg::*;
#(
  parameter int DLY_W = 16,
  parameter int PRESC = 128
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             done_i,
  input  logic [DLY_W-1:0] pkt_dly_i,
  input  logic [DLY_W-1:0] abs_dly_i,
  input  logic             cancel_i,
  output dir_stat_t        stat_o
);
  logic pkt_nz, abs_nz;
  logic pkt_restart, abs_start;
  logic pkt_busy, abs_busy, pkt_exp, abs_exp;

  assign pkt_nz      = |pkt_dly_i;
  assign abs_nz      = |abs_dly_i;
  assign pkt_restart = done_i & pkt_nz;
  assign abs_start   = done_i & pkt_nz & abs_nz;

  idt_timer #(.DLY_W(DLY_W), .PRESC(PRESC)) u_pkt (
    .clk_i, .rst_ni,
    .restart_i (pkt_restart),
    .start_i   (1'b0),
    .cancel_i,
    .delay_i   (pkt_dly_i),
    .busy_o    (pkt_busy),
    .expire_o  (pkt_exp)
  );

  idt_timer #(.DLY_W(DLY_W), .PRESC(PRESC)) u_abs (
    .clk_i, .rst_ni,
    .restart_i (1'b0),
    .start_i   (abs_start),
    .cancel_i,
    .delay_i   (abs_dly_i),
    .busy_o    (abs_busy),
    .expire_o  (abs_exp)
  );

  assign stat_o.pkt_busy = pkt_busy;
  assign stat_o.abs_busy = abs_busy;
  assign stat_o.expire   = pkt_exp | abs_exp;
  assign stat_o.arm      = pkt_restart;
endmodule

// File: rtl/int_delay_timers.sv
module int_delay_timers
  import idt_pkg::*;
#(
  parameter int CLK_NS  = 8,
  parameter int TICK_NS = 1024,
  parameter int DLY_W   = 16,
  parameter int LEN_W   = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rx_done_i,
  input  logic [LEN_W-1:0] rx_len_i,
  input  logic             tx_done_i,
  input  logic             tx_dly_en_i,
  input  logic [DLY_W-1:0] rx_pkt_dly_i,
  input  logic [DLY_W-1:0] rx_abs_dly_i,
  input  logic [DLY_W-1:0] tx_pkt_dly_i,
  input  logic [DLY_W-1:0] tx_abs_dly_i,
  input  logic [LEN_W-1:0] small_thr_i,
  input  logic             dly_rd_i,
  input  logic             flush_bit_i,
  input  logic             int_post_i,
  output logic             rx_cause_o,
  output logic             tx_cause_o,
  output logic             small_cause_o,
  output logic             flush_clr_o,
  output logic             rx_pkt_busy_o,
  output logic             rx_abs_busy_o,
  output logic             tx_pkt_busy_o,
  output logic             tx_abs_busy_o
);
  localparam int PRESC = TICK_NS / CLK_NS;

  logic                 done   [NUM_DIR];
  logic [DLY_W-1:0]     pkt_dly[NUM_DIR];
  logic [DLY_W-1:0]     abs_dly[NUM_DIR];
  dir_stat_t            stat   [NUM_DIR];
  logic [NUM_DIR-1:0]   pending;
  logic [NUM_DIR-1:0]   expired;

  logic rx_now, small_now, flush_now, fire;
  logic rx_cause_d, tx_cause_d;

  assign done[DIR_RX]    = rx_done_i;
  assign done[DIR_TX]    = tx_done_i & tx_dly_en_i;
  assign pkt_dly[DIR_RX] = rx_pkt_dly_i;
  assign pkt_dly[DIR_TX] = tx_pkt_dly_i;
  assign abs_dly[DIR_RX] = rx_abs_dly_i;
  assign abs_dly[DIR_TX] = tx_abs_dly_i;

  for (genvar d = 0; d < NUM_DIR; d++) begin : g_dir
    idt_dir_pair #(.DLY_W(DLY_W), .PRESC(PRESC)) u_pair (
      .clk_i, .rst_ni,
      .done_i    (done[d]),
      .pkt_dly_i (pkt_dly[d]),
      .abs_dly_i (abs_dly[d]),
      .cancel_i  (fire),
      .stat_o    (stat[d])
    );
    // running or arming this cycle: folded into any posting
    assign pending[d] = stat[d].pkt_busy | stat[d].abs_busy | stat[d].arm;
    assign expired[d] = stat[d].expire;
  end

  assign rx_now    = rx_done_i & ~(|rx_pkt_dly_i);
  assign small_now = rx_done_i & (rx_len_i <= small_thr_i);
  assign flush_now = dly_rd_i & flush_bit_i;
  assign fire      = int_post_i | rx_now | small_now | flush_now | (|expired);

  assign rx_cause_d = rx_now | flush_now | (fire & pending[DIR_RX]);
  assign tx_cause_d = fire & pending[DIR_TX];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_cause_o    <= 1'b0;
      tx_cause_o    <= 1'b0;
      small_cause_o <= 1'b0;
      flush_clr_o   <= 1'b0;
    end else begin
      rx_cause_o    <= rx_cause_d;
      tx_cause_o    <= tx_cause_d;
      small_cause_o <= small_now;
      flush_clr_o   <= flush_now;
    end
  end

  assign rx_pkt_busy_o = stat[DIR_RX].pkt_busy;
  assign rx_abs_busy_o = stat[DIR_RX].abs_busy;
  assign tx_pkt_busy_o = stat[DIR_TX].pkt_busy;
  assign tx_abs_busy_o = stat[DIR_TX].abs_busy;
endmodule

// File: rtl/idt_checker.sv
module idt_checker #(
  parameter int DLY_W = 16,
  parameter int LEN_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             rx_done_i,
  input logic [LEN_W-1:0] rx_len_i,
  input logic             tx_done_i,
  input logic             tx_dly_en_i,
  input logic [DLY_W-1:0] rx_pkt_dly_i,
  input logic [LEN_W-1:0] small_thr_i,
  input logic             dly_rd_i,
  input logic             flush_bit_i,
  input logic             int_post_i,
  input logic             rx_cause_o,
  input logic             tx_cause_o,
  input logic             small_cause_o,
  input logic             flush_clr_o,
  input logic             rx_pkt_busy_o,
  input logic             rx_abs_busy_o,
  input logic             tx_pkt_busy_o,
  input logic             tx_abs_busy_o
);
  AST_RX_IMMEDIATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_done_i && rx_pkt_dly_i == '0 |=> rx_cause_o && !rx_pkt_busy_o); // R3

  AST_SMALL_PKT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_done_i && rx_len_i <= small_thr_i |=> small_cause_o); // R5

  AST_TX_NO_DLY_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_done_i && !tx_dly_en_i && !tx_pkt_busy_o && !tx_abs_busy_o
    |=> !tx_pkt_busy_o && !tx_abs_busy_o); // R6

  AST_POST_CANCELS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_post_i |=> !rx_pkt_busy_o && !rx_abs_busy_o && !tx_pkt_busy_o && !tx_abs_busy_o); // R7

  AST_TX_CAUSE_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_cause_o |-> $past(tx_pkt_busy_o || tx_abs_busy_o || (tx_done_i && tx_dly_en_i))); // R7

  AST_FLUSH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dly_rd_i && flush_bit_i |=> rx_cause_o && flush_clr_o); // R8

  AST_RX_IDLE_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rx_pkt_busy_o) || $fell(rx_abs_busy_o) |-> rx_cause_o); // R9

  AST_TX_IDLE_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(tx_pkt_busy_o) || $fell(tx_abs_busy_o) |-> tx_cause_o); // R9
endmodule

bind int_delay_timers idt_checker #(.DLY_W(DLY_W), .LEN_W(LEN_W)) u_idt_checker (
  .clk_i, .rst_ni, .rx_done_i, .rx_len_i, .tx_done_i, .tx_dly_en_i,
  .rx_pkt_dly_i, .small_thr_i, .dly_rd_i, .flush_bit_i, .int_post_i,
  .rx_cause_o, .tx_cause_o, .small_cause_o, .flush_clr_o,
  .rx_pkt_busy_o, .rx_abs_busy_o, .tx_pkt_busy_o, .tx_abs_busy_o
);

// File: tb/int_delay_timers_bench.sv
module int_delay_timers_bench;
  localparam int CLK_PERIOD = 8;
  localparam int PRESC      = 1024 / CLK_PERIOD;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        rx_done_i = 1'b0;
  logic [15:0] rx_len_i = 16'd1500;
  logic        tx_done_i = 1'b0;
  logic        tx_dly_en_i = 1'b0;
  logic [15:0] rx_pkt_dly_i = '0, rx_abs_dly_i = '0;
  logic [15:0] tx_pkt_dly_i = '0, tx_abs_dly_i = '0;
  logic [15:0] small_thr_i = 16'd64;
  logic        dly_rd_i = 1'b0, flush_bit_i = 1'b0, int_post_i = 1'b0;
  logic        rx_cause_o, tx_cause_o, small_cause_o, flush_clr_o;
  logic        rx_pkt_busy_o, rx_abs_busy_o, tx_pkt_busy_o, tx_abs_busy_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  int_delay_timers #(.CLK_NS(CLK_PERIOD)) u_int_delay_timers (
    .clk_i(clk), .rst_ni, .rx_done_i, .rx_len_i, .tx_done_i, .tx_dly_en_i,
    .rx_pkt_dly_i, .rx_abs_dly_i, .tx_pkt_dly_i, .tx_abs_dly_i, .small_thr_i,
    .dly_rd_i, .flush_bit_i, .int_post_i,
    .rx_cause_o, .tx_cause_o, .small_cause_o, .flush_clr_o,
    .rx_pkt_busy_o, .rx_abs_busy_o, .tx_pkt_busy_o, .tx_abs_busy_o
  );

  typedef struct {
    int          cyc;
    logic [2:0]  v;   // {rx, tx, small}
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  int   cyc = 0;
  int   n_chk = 0, n_fail = 0;
  bit   done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: compare cause outputs against the scoreboard queue
  always @(negedge clk) begin
    if (rst_ni && !done) begin
      logic [2:0] act;
      act = {rx_cause_o, tx_cause_o, small_cause_o};
      while (exp_q.size() > 0 && exp_q[0].cyc < cyc) begin
        n_chk++; n_fail++;
        $display("FAIL %s: cause missed at cycle %0d, actual 000 expected %b",
                 exp_q[0].tag, exp_q[0].cyc, exp_q[0].v);
        void'(exp_q.pop_front());
      end
      if (exp_q.size() > 0 && exp_q[0].cyc == cyc) begin
        n_chk++;
        if (act !== exp_q[0].v) begin
          n_fail++;
          $display("FAIL %s: cycle %0d causes actual %b expected %b",
                   exp_q[0].tag, cyc, act, exp_q[0].v);
        end
        void'(exp_q.pop_front());
      end else if (act !== 3'b000) begin
        n_chk++; n_fail++;
        $display("FAIL R7/R10: unexpected causes at cycle %0d actual %b expected 000", cyc, act);
      end
    end
  end

  task automatic check(input logic got, input logic expv, input string tag);
    n_chk++;
    if (got !== expv) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", tag, got, expv);
    end
  endtask

  task automatic push(input int c, input logic [2:0] v, input string tag);
    exp_q.push_back('{cyc: c, v: v, tag: tag});
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // each pulse task returns the cycle count seen before the sampling edge
  task automatic rx_pulse(input logic [15:0] len, output int base);
    rx_len_i = len; rx_done_i = 1'b1; base = cyc;
    tick(1);
    rx_done_i = 1'b0;
  endtask

  task automatic tx_pulse(input logic en, output int base);
    tx_dly_en_i = en; tx_done_i = 1'b1; base = cyc;
    tick(1);
    tx_done_i = 1'b0; tx_dly_en_i = 1'b0;
  endtask

  task automatic post_pulse(output int base);
    int_post_i = 1'b1; base = cyc;
    tick(1);
    int_post_i = 1'b0;
  endtask

  task automatic drain;
    while (exp_q.size() > 0) tick(1);
    tick(4);
  endtask

  initial begin
    int b, b2;
    tick(3);
    // R1: reset state
    check(rx_cause_o | tx_cause_o | small_cause_o | flush_clr_o, 1'b0, "R1 causes in reset");
    check(rx_pkt_busy_o | rx_abs_busy_o | tx_pkt_busy_o | tx_abs_busy_o, 1'b0, "R1 busy in reset");
    rst_ni = 1'b1;
    tick(2);

    // R2/R9: single arm, expiry after D*PRESC cycles
    rx_pkt_dly_i = 16'd2;
    rx_pulse(16'd1500, b);
    check(rx_pkt_busy_o, 1'b1, "R2 pkt timer running");
    check(rx_abs_busy_o, 1'b0, "R4 abs idle when abs delay zero");
    push(b + 1 + 2*PRESC, 3'b100, "R2");
    drain();
    check(rx_pkt_busy_o, 1'b0, "R9 pkt timer idle after expiry");

    // R2: restart by a second completion
    rx_pulse(16'd1500, b);
    tick(99);
    rx_pulse(16'd1500, b2);
    push(b2 + 1 + 2*PRESC, 3'b100, "R2 restart");
    drain();

    // R3: zero packet delay
    rx_pkt_dly_i = 16'd0;
    rx_pulse(16'd1500, b);
    push(b + 1, 3'b100, "R3");
    check(rx_pkt_busy_o, 1'b0, "R3 no timer armed");
    drain();

    // R5: small packet, zero delay and then nonzero delay (folded, R7)
    rx_pulse(16'd64, b);
    push(b + 1, 3'b101, "R5 at threshold");
    drain();
    rx_pkt_dly_i = 16'd3;
    rx_pulse(16'd40, b);
    push(b + 1, 3'b101, "R5/R7 small folds arming");
    check(rx_pkt_busy_o, 1'b0, "R7 arming cancelled by small cause");
    drain();

    // R4: absolute timer caps, not restarted
    rx_pkt_dly_i = 16'd2; rx_abs_dly_i = 16'd3;
    rx_pulse(16'd1500, b);
    check(rx_abs_busy_o, 1'b1, "R4 abs started");
    tick(199);
    rx_pulse(16'd1500, b2);
    push(b + 1 + 3*PRESC, 3'b100, "R4 abs cap");
    drain();
    check(rx_pkt_busy_o | rx_abs_busy_o, 1'b0, "R4 both idle after abs expiry");
    rx_abs_dly_i = 16'd0;

    // R6: transmit without and with delay enable
    tx_pkt_dly_i = 16'd1; tx_abs_dly_i = 16'd4;
    tx_pulse(1'b0, b);
    check(tx_pkt_busy_o | tx_abs_busy_o, 1'b0, "R6 no arm without enable");
    tick(20);
    tx_pulse(1'b1, b);
    check(tx_abs_busy_o, 1'b1, "R6 tx abs started");
    push(b + 1 + PRESC, 3'b010, "R6 tx expiry");
    drain();

    // R10: posting with nothing running
    post_pulse(b);
    tick(5);

    // R7: fold both directions on external posting
    rx_pkt_dly_i = 16'd4; tx_pkt_dly_i = 16'd4; tx_abs_dly_i = 16'd0;
    rx_pulse(16'd1500, b);
    tx_pulse(1'b1, b);
    tick(10);
    post_pulse(b);
    push(b + 1, 3'b110, "R7 fold");
    check(rx_pkt_busy_o | tx_pkt_busy_o, 1'b0, "R7 timers cancelled");
    drain();

    // R8: flush
    dly_rd_i = 1'b1; flush_bit_i = 1'b1; b = cyc;
    tick(1);
    dly_rd_i = 1'b0;
    push(b + 1, 3'b100, "R8 flush");
    check(flush_clr_o, 1'b1, "R8 flush clear request");
    drain();
    flush_bit_i = 1'b0;
    dly_rd_i = 1'b1;
    tick(1);
    dly_rd_i = 1'b0;
    check(flush_clr_o, 1'b0, "R8 no clear without flush bit");
    tick(5);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule